// File: doc/BRIEF.md
# Mode-Selected PLL Divider Chain

This block holds both counting chains of a frequency synthesiser loop. The reference chain divides the crystal reference by one of five fixed ratios picked by a 3-bit mode code, and its output is the comparison clock for the phase detector. The feedback chain divides the VCO clock by a programmable 15-bit divisor. That VCO clock has already passed an external divide-by-16 stage, so the tuning step is sixteen times the comparison rate (125 kHz in mode 4 with a 4 MHz crystal). The two chain outputs go to the phase comparator as its two inputs.

Both chains run on a single system clock. Each source clock arrives as a one-cycle tick enable. A divisor word arrives with a load strobe and a frame-length flag. A short (18-bit) frame carries only 14 divisor bits. A new divisor waits in a pending register and replaces the active value only at terminal count, so no feedback period is ever cut short.

The feedback controller has two states:
- FB_RUN: no pending divisor.
- FB_ARMED: a pending divisor waits for terminal count.

Its transitions are:
- LOAD (FB_RUN to FB_ARMED): a strobe arrives while the count is not terminal.
- SWAP (FB_ARMED to FB_RUN): terminal count is reached.
- REFRESH (FB_ARMED to FB_ARMED): a new strobe replaces the pending value.
- DIRECT (FB_RUN to FB_RUN): a strobe lands on the terminal-count cycle, and its word is used at once.

Top module: `pll_div_chain`

## Requirements
- R1: While reset is asserted, and afterwards until the first tick, both pulse outputs and both half-rate outputs are 0.
- R2: Mode codes map to reference ratios as follows: 0 gives 640, 1 gives 2048, 2 gives 1024, 3 gives 1280 and 4 gives 512. The ratio is the number of reference ticks between `fcomp_pulse` assertions.
- R3: Mode codes 5, 6 and 7 give a ratio of 1024, the same as code 2.
- R4: Each chain counts only cycles in which its tick input is 1. Each pulse output is high for exactly one clock cycle, in the cycle after the tick that reaches terminal count.
- R5: A change of mode code takes effect from the period that starts after the next `fcomp_pulse`. The period already running finishes with the old ratio.
- R6: The feedback chain asserts `fpd_pulse` once every D VCO ticks, where D is the active divisor.
- R7: With `div_long`=0, bit 14 of `div_word` is treated as 0. With `div_long`=1, all 15 bits are used.
- R8: A divisor that evaluates to 0 or 1, after the bit-14 masking, is used as 2.
- R9: A divisor loaded in mid-period takes effect only after the current period ends. If several words are loaded before then, the last one wins.
- R10: `fcomp_half` and `fpd_half` toggle in exactly the cycles in which their pulse outputs are high. They are otherwise stable, so each is a 50% duty clock at half the pulse rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference clock edge |
| vco_tick | input | 1 | One-cycle enable per prescaled VCO clock edge |
| mode | input | 3 | Operating mode code |
| div_word | input | 15 | Feedback divisor word |
| div_long | input | 1 | 1 for a 19-bit frame (15-bit divisor), 0 for an 18-bit frame |
| div_load | input | 1 | Divisor load strobe |
| fcomp_pulse | output | 1 | Comparison-clock pulse, one cycle per reference period |
| fcomp_half | output | 1 | Comparison clock divided by 2 |
| fpd_pulse | output | 1 | Feedback-clock pulse, one cycle per divisor period |
| fpd_half | output | 1 | Feedback clock divided by 2 |

## Verification
The hardest situation to reach from the ports is a divisor swap in the middle of a period. It needs a load strobe that arrives while a long count is still running, followed by a second load before terminal count. The bench first aligns to an `fpd_pulse`, then loads a large divisor so that the next full period is long. A few cycles into that period it loads a small value, and in another run it loads two values in a row. It then measures the two following periods. The first must show the old length and the second the new one, with no shortened period in between. Mode changes are checked the same way: the bench switches the code on the cycle a comparison pulse appears.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    localparam int REF_CNT_W   = 11;
    localparam int RATIO_MODE0 = 640;
    localparam int RATIO_MODE1 = 2048;
    localparam int RATIO_MODE2 = 1024;
    localparam int RATIO_MODE3 = 1280;
    localparam int RATIO_MODE4 = 512;

    typedef enum logic {
        FB_RUN   = 1'b0,
        FB_ARMED = 1'b1
    } fb_state_e;

    // Reload value (ratio minus one) for a mode code; unused codes fall back to mode 2
    function automatic logic [REF_CNT_W-1:0] ref_reload(input logic [2:0] code);
        int r;
        case (code)
            3'd0:    r = RATIO_MODE0;
            3'd1:    r = RATIO_MODE1;
            3'd3:    r = RATIO_MODE3;
            3'd4:    r = RATIO_MODE4;
            default: r = RATIO_MODE2;
        endcase
        return REF_CNT_W'(r - 1);
    endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div
    import pll_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] mode,
    output logic       pulse,
    output logic       half
);

    logic [REF_CNT_W-1:0] cnt;
    logic                 tc;

    assign tc = tick && (cnt == '0);

    // count register: reload picks the ratio for the mode seen at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tc) begin
            cnt <= ref_reload(mode);
        end else if (tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            half  <= 1'b0;
        end else begin
            pulse <= tc;
            if (tc) begin
                half <= ~half;
            end
        end
    end

endmodule

// File: rtl/pll_word_fmt.sv
module pll_word_fmt #(
    parameter int DIV_W   = 15,
    parameter int DIV_MIN = 2
) (
    input  logic [DIV_W-1:0] word,
    input  logic             long_frame,
    output logic [DIV_W-1:0] divisor
);

    logic [DIV_W-1:0] masked;

    always_comb begin
        masked = word;
        if (!long_frame) begin
            masked[DIV_W-1] = 1'b0;
        end
        if (masked < DIV_W'(DIV_MIN)) begin
            divisor = DIV_W'(DIV_MIN);
        end else begin
            divisor = masked;
        end
    end

endmodule

// File: rtl/pll_fb_div.sv
module pll_fb_div
    import pll_div_pkg::*;
#(
    parameter int DIV_W   = 15,
    parameter int DIV_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [DIV_W-1:0] new_div,
    output logic             pulse,
    output logic             half
);

    fb_state_e        state, state_nx;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] active;
    logic [DIV_W-1:0] pending;
    logic [DIV_W-1:0] reload_val;
    logic             tc;

    assign tc = tick && (cnt == '0);

    always_comb begin
        state_nx   = state;
        reload_val = active;
        unique case (state)
            FB_RUN: begin
                if (load && !tc) begin
                    state_nx = FB_ARMED;           // LOAD
                end
                if (load) begin
                    reload_val = new_div;          // DIRECT when tc
                end
            end
            FB_ARMED: begin
                if (tc) begin
                    state_nx = FB_RUN;             // SWAP
                end
                reload_val = load ? new_div : pending;  // REFRESH wins
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FB_RUN;
            cnt     <= '0;
            active  <= DIV_W'(DIV_MIN);
            pending <= DIV_W'(DIV_MIN);
        end else begin
            state <= state_nx;
            if (load) begin
                pending <= new_div;
            end
            if (tc) begin
                active <= reload_val;
                cnt    <= reload_val - 1'b1;
            end else if (tick) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            half  <= 1'b0;
        end else begin
            pulse <= tc;
            if (tc) begin
                half <= ~half;
            end
        end
    end

endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
    parameter int DIV_W   = 15,
    parameter int DIV_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             vco_tick,
    input  logic [2:0]       mode,
    input  logic [DIV_W-1:0] div_word,
    input  logic             div_long,
    input  logic             div_load,
    output logic             fcomp_pulse,
    output logic             fcomp_half,
    output logic             fpd_pulse,
    output logic             fpd_half
);

    logic [DIV_W-1:0] fmt_div;

    pll_ref_div u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .mode  (mode),
        .pulse (fcomp_pulse),
        .half  (fcomp_half)
    );

    pll_word_fmt #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_fmt (
        .word       (div_word),
        .long_frame (div_long),
        .divisor    (fmt_div)
    );

    pll_fb_div #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (vco_tick),
        .load    (div_load),
        .new_div (fmt_div),
        .pulse   (fpd_pulse),
        .half    (fpd_half)
    );

endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic vco_tick,
    input logic fcomp_pulse,
    input logic fcomp_half,
    input logic fpd_pulse,
    input logic fpd_half
);

    AST_FCOMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fcomp_pulse |=> !fcomp_pulse);                                   // R4
    AST_FPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fpd_pulse |=> !fpd_pulse);                                       // R6
    AST_FCOMP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fcomp_pulse) |-> $past(ref_tick));                         // R4
    AST_FPD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fpd_pulse) |-> $past(vco_tick));                           // R4
    AST_FCOMP_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fcomp_pulse |-> (fcomp_half != $past(fcomp_half)));              // R10
    AST_FCOMP_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fcomp_pulse |-> $stable(fcomp_half));                           // R10
    AST_FPD_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fpd_pulse |-> (fpd_half != $past(fpd_half)));                    // R10
    AST_FPD_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fpd_pulse |-> $stable(fpd_half));                               // R10

endmodule

bind pll_div_chain pll_div_chain_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick    (ref_tick),
    .vco_tick    (vco_tick),
    .fcomp_pulse (fcomp_pulse),
    .fcomp_half  (fcomp_half),
    .fpd_pulse   (fpd_pulse),
    .fpd_half    (fpd_half)
);

// File: tb/pll_div_chain_tb.sv
`timescale 1ns/1ps
module pll_div_chain_tb;

    localparam int LIMIT = 40000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        vco_tick = 1'b0;
    logic [2:0]  mode = 3'd2;
    logic [14:0] div_word = '0;
    logic        div_long = 1'b0;
    logic        div_load = 1'b0;
    logic        fcomp_pulse, fcomp_half, fpd_pulse, fpd_half;

    logic ref_en = 1'b0;
    logic ref_gate = 1'b0;
    bit   half_mon = 1'b0;
    logic exp_fcomp_half = 1'b0;
    logic exp_fpd_half = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;

    always #5 clk = ~clk;

    pll_div_chain u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .mode(mode), .div_word(div_word), .div_long(div_long), .div_load(div_load),
        .fcomp_pulse(fcomp_pulse), .fcomp_half(fcomp_half),
        .fpd_pulse(fpd_pulse), .fpd_half(fpd_half)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference tick source: steady or every other cycle
    always @(negedge clk) begin
        if (ref_gate) ref_tick <= ~ref_tick;
        else          ref_tick <= ref_en;
    end

    // half-rate monitor (R10)
    always @(negedge clk) begin
        if (half_mon) begin
            if (fcomp_pulse) begin
                exp_fcomp_half = ~exp_fcomp_half;
                chk("R10 fcomp_half", int'(fcomp_half), int'(exp_fcomp_half));
            end
            if (fpd_pulse) begin
                exp_fpd_half = ~exp_fpd_half;
                chk("R10 fpd_half", int'(fpd_half), int'(exp_fpd_half));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_fcomp();
        int n = 0;
        do begin @(negedge clk); n++; end while (!fcomp_pulse && n < LIMIT);
    endtask

    task automatic measure_fcomp(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!fcomp_pulse && n < LIMIT);
    endtask

    task automatic wait_fpd();
        int n = 0;
        do begin @(negedge clk); n++; end while (!fpd_pulse && n < LIMIT);
    endtask

    task automatic measure_fpd(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!fpd_pulse && n < LIMIT);
    endtask

    task automatic load_div(input logic [14:0] w, input logic lng);
        div_word = w;
        div_long = lng;
        div_load = 1'b1;
        @(negedge clk);
        div_load = 1'b0;
    endtask

    function automatic int ratio_of(input int m);
        case (m)
            0: return 640;
            1: return 2048;
            3: return 1280;
            4: return 512;
            default: return 1024;
        endcase
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 fcomp_pulse in reset", int'(fcomp_pulse), 0);
        chk("R1 fpd_pulse in reset", int'(fpd_pulse), 0);
        chk("R1 fcomp_half in reset", int'(fcomp_half), 0);
        chk("R1 fpd_half in reset", int'(fpd_half), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 fcomp_pulse without ticks", int'(fcomp_pulse | fcomp_half), 0);
        chk("R1 fpd_pulse without ticks", int'(fpd_pulse | fpd_half), 0);
        half_mon = 1'b1;
    endtask

    task automatic t_ref_modes();
        int n;
        ref_en = 1'b1;
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m);
            wait_fcomp();
            measure_fcomp(n);
            if (m < 5) chk($sformatf("R2 mode %0d ratio", m), n, ratio_of(m));
            else       chk($sformatf("R3 mode %0d ratio", m), n, 1024);
        end
    endtask

    task automatic t_tick_gate();
        int n;
        mode = 3'd4;
        wait_fcomp();
        ref_gate = 1'b1;
        wait_fcomp();
        measure_fcomp(n);
        chk("R4 half-rate ticks period", n, 1024);
        ref_gate = 1'b0;
        ref_en = 1'b1;
        wait_fcomp();
    endtask

    task automatic t_mode_change();
        int n;
        mode = 3'd4;
        wait_fcomp();
        wait_fcomp();
        mode = 3'd0;
        measure_fcomp(n);
        chk("R5 period in progress keeps old ratio", n, 512);
        measure_fcomp(n);
        chk("R5 next period uses new ratio", n, 640);
    endtask

    task automatic t_fb_basic();
        int n;
        vco_tick = 1'b1;
        load_div(15'd7, 1'b1);
        wait_fpd();
        wait_fpd();
        for (int i = 0; i < 3; i++) begin
            measure_fpd(n);
            chk("R6 feedback period", n, 7);
        end
    endtask

    task automatic t_fb_frame();
        int n;
        load_div(15'h4005, 1'b0);
        wait_fpd(); wait_fpd();
        measure_fpd(n);
        chk("R7 short frame masks bit 14", n, 5);
        load_div(15'h4003, 1'b1);
        wait_fpd(); wait_fpd();
        measure_fpd(n);
        chk("R7 long frame uses bit 14", n, 16387);
    endtask

    task automatic t_fb_clamp();
        int n;
        load_div(15'd0, 1'b1);
        wait_fpd(); wait_fpd();
        measure_fpd(n);
        chk("R8 divisor 0 clamps to 2", n, 2);
        load_div(15'h4001, 1'b0);
        wait_fpd(); wait_fpd();
        measure_fpd(n);
        chk("R8 masked divisor 1 clamps to 2", n, 2);
    endtask

    task automatic t_fb_swap();
        int n;
        load_div(15'd20, 1'b1);
        wait_fpd(); wait_fpd();
        repeat (4) @(negedge clk);
        load_div(15'd3, 1'b1);
        measure_fpd(n);
        chk("R9 period in progress finishes at old divisor", n, 20 - 5);
        measure_fpd(n);
        chk("R9 new divisor after terminal count", n, 3);
        load_div(15'd30, 1'b1);
        wait_fpd(); wait_fpd();
        load_div(15'd9, 1'b1);
        load_div(15'd4, 1'b1);
        measure_fpd(n);
        chk("R9 old divisor with two pending loads", n, 30 - 2);
        measure_fpd(n);
        chk("R9 last loaded divisor wins", n, 4);
    endtask

    initial begin
        t_reset();
        t_ref_modes();
        t_tick_gate();
        t_mode_change();
        t_fb_basic();
        t_fb_frame();
        t_fb_clamp();
        t_fb_swap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule